// File: doc/BRIEF.md
# Cascadable Four-Channel Countdown Timer Group

The block holds four down-counting timers that share one prescaled time base and a small memory-mapped register port. Each timer reloads from its own base value every time it runs out, so a started timer gives a steady train of interrupts. Each interrupt is an active-low level. It stays asserted until software reads that timer's count register.

A group control register picks the prescaler division and can chain two neighbouring timers into one long counter. In a chained pair the lower timer counts the fine part over a full 32-bit range. The upper timer counts the rollovers of the lower one. Only the upper timer of a pair raises an interrupt, and it does so once per full pair period. Each timer also has two words of plain storage that software uses for interrupt routing.

The register port is synchronous. A write takes effect at the clock edge while `we` is high. Read data is combinational from `addr`. Timer `t` sits at byte offset `t*0x40`, with four words inside it: count at +0x00, base at +0x10, routing word A at +0x20 and routing word B at +0x30. The group control word sits at 0x100.

Top module: `cascade_timer_group`

## Requirements
- R1: After reset every base register reads 0x8000_0000 (stopped, reload 0), every count register and the group control register read 0, and `irq_n` is 4'hF.
- R2: The routing words A and B of each timer read back what was last written. The group control word keeps only bits 2:0 (chain enables), 9:8 (prescaler select) and 26:24 (chain confirms), and reads 0 elsewhere.
- R3: Prescaler select values 0, 1, 2 and 3 give one count tick every 8, 16, 32 and 64 clocks. A running stand-alone timer with reload N reaches its terminal count every (N+1) ticks.
- R4: Bit 31 of a stand-alone or upper timer's count register inverts at each terminal count. Bits 30:0 then reload from base bits 30:0.
- R5: While base bit 31 (stop) is 1, the count of a stand-alone timer does not change. Any write to a count register sets it to 0.
- R6: Writing a base word with bit 31 = 0 to a stopped timer loads count bits 30:0 from the written value at once, with bit 31 cleared. A base write to a running timer does not reload the count.
- R7: Timers c and c+1 form a chained pair when control bits c and 24+c are both 1. Starting the upper timer loads the lower count with the whole 32-bit lower base. The upper timer then terminates every (U+1)*(L+1) ticks, where U is the upper reload and L is the full 32-bit lower base.
- R8: The lower timer of a chained pair never asserts its interrupt. Its own stop bit is ignored, and it counts only while the upper timer runs.
- R9: A chain enable bit without its confirm bit leaves both timers stand-alone.
- R10: When overlapping pairs are requested, the lower-numbered pair wins. A timer whose pair loses stays stand-alone.
- R11: A terminal count of a stand-alone or upper timer drives its `irq_n` bit low. The bit stays low until that timer's count register is read with `re` high, and it is released at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we | input | 1 | Write strobe |
| re | input | 1 | Read strobe; a read of a count register acknowledges that timer's interrupt |
| addr | input | 9 | Byte address of the register word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq_n | output | 4 | Per-timer interrupt, active low, level |

## Verification
The assertions assume the bus never writes a count or base word of a stopped stand-alone timer except where the hold rule allows it. They also assume the prescaler select is one of the four legal codes, so a tick can never follow another tick. The stimulus changes the group control word only while every timer involved is stopped. It acknowledges each interrupt well inside the shortest period, so every falling edge of `irq_n` marks a fresh terminal count. Periods are measured between two consecutive falling edges, which makes the prescaler phase at start-up irrelevant.

// File: rtl/cascade_timer_group.sv
module cascade_timer_group #(
  parameter int DIV_LOG2 = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic        re,
  input  logic [8:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [3:0]  irq_n
);
  localparam int NT = 4;
  localparam int PRE_W = DIV_LOG2 + 3;
  localparam logic [8:0] CTRL_ADDR = 9'h100;

  logic [31:0] base [NT];
  logic [31:0] cnt  [NT];
  logic [31:0] rta  [NT];
  logic [31:0] rtb  [NT];
  logic [NT-1:0] pend;
  logic [1:0] psel;
  logic [2:0] chain_en, chain_ok;
  logic [PRE_W-1:0] pre, lim;
  logic tick;

  assign lim  = PRE_W'((1 << (DIV_LOG2 + int'(psel))) - 1);
  assign tick = (pre >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n) pre <= '0;
    else        pre <= tick ? '0 : pre + 1'b1;
  end

  logic [2:0] jn;
  logic [NT-1:0] lo, up;
  assign jn[0] = chain_en[0] & chain_ok[0];
  assign jn[1] = chain_en[1] & chain_ok[1] & ~jn[0];
  assign jn[2] = chain_en[2] & chain_ok[2] & ~jn[1];
  assign lo = {1'b0, jn};
  assign up = {jn, 1'b0};

  logic hit_t, hit_c;
  logic [1:0] ts, rs;
  assign hit_t = ~addr[8] && (addr[3:0] == 4'd0);
  assign hit_c = (addr == CTRL_ADDR);
  assign ts = addr[7:6];
  assign rs = addr[5:4];

  logic [NT-1:0] wr_cnt, wr_base, wr_a, wr_b, rd_cnt, start, run, step, term;

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    localparam int U = (i + 1) % NT;
    localparam int L = (i + NT - 1) % NT;
    assign wr_cnt[i]  = we & hit_t & (ts == 2'(i)) & (rs == 2'd0);
    assign wr_base[i] = we & hit_t & (ts == 2'(i)) & (rs == 2'd1);
    assign wr_a[i]    = we & hit_t & (ts == 2'(i)) & (rs == 2'd2);
    assign wr_b[i]    = we & hit_t & (ts == 2'(i)) & (rs == 2'd3);
    assign rd_cnt[i]  = re & hit_t & (ts == 2'(i)) & (rs == 2'd0);
    assign start[i]   = wr_base[i] & ~wdata[31] & base[i][31];
    assign run[i]     = lo[i] ? ~base[U][31] : ~base[i][31];
    assign step[i]    = tick & run[i] & (~up[i] | (cnt[L] == 32'd0));
    assign term[i]    = step[i] & ~lo[i] & (cnt[i][30:0] == 31'd0);

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (base[i][31] && !lo[i] && !wr_cnt[i] && !wr_base[i]) |=> $stable(cnt[i])); // R5

    AST_IRQ_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_n[i]) |-> $past(tick)); // R11

    if (i < NT - 1) begin : g_low
      AST_LOWER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (lo[i] && $past(lo[i])) |-> !$fell(irq_n[i])); // R8
    end
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R3

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psel     <= '0;
      chain_en <= '0;
      chain_ok <= '0;
      pend     <= '0;
      for (int i = 0; i < NT; i++) begin
        base[i] <= 32'h8000_0000;
        cnt[i]  <= '0;
        rta[i]  <= '0;
        rtb[i]  <= '0;
      end
    end else begin
      if (we && hit_c) begin
        chain_en <= wdata[2:0];
        psel     <= wdata[9:8];
        chain_ok <= wdata[26:24];
      end
      for (int i = 0; i < NT; i++) begin
        if (wr_base[i]) base[i] <= wdata;
        if (wr_a[i])    rta[i]  <= wdata;
        if (wr_b[i])    rtb[i]  <= wdata;
        if (wr_cnt[i])
          cnt[i] <= '0;
        else if (lo[i] && start[(i + 1) % NT])
          cnt[i] <= base[i];
        else if (!lo[i] && start[i])
          cnt[i] <= {1'b0, wdata[30:0]};
        else if (step[i]) begin
          if (lo[i])
            cnt[i] <= (cnt[i] == 32'd0) ? base[i] : cnt[i] - 32'd1;
          else if (term[i])
            cnt[i] <= {~cnt[i][31], base[i][30:0]};
          else
            cnt[i] <= {cnt[i][31], cnt[i][30:0] - 31'd1};
        end
        pend[i] <= term[i] | (pend[i] & ~rd_cnt[i]);
      end
    end
  end

  assign irq_n = ~pend;

  always_comb begin
    rdata = '0;
    if (hit_c)
      rdata = {5'd0, chain_ok, 14'd0, psel, 5'd0, chain_en};
    else if (hit_t) begin
      case (rs)
        2'd0:    rdata = cnt[ts];
        2'd1:    rdata = base[ts];
        2'd2:    rdata = rta[ts];
        default: rdata = rtb[ts];
      endcase
    end
  end
endmodule

// File: tb/cascade_timer_group_tb.sv
module cascade_timer_group_tb;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, re = 1'b0;
  logic [8:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0] irq_n;

  cascade_timer_group u_dut (.clk(clk), .rst_n(rst_n), .we(we), .re(re),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n));

  always #2 clk = ~clk;

  int cyc = 0, checks = 0, errors = 0, low_falls = 0;
  bit done = 0;
  logic prev0 = 1'b1;
  always @(posedge clk) cyc++;
  always @(negedge clk) begin
    if (prev0 && !irq_n[0]) low_falls++;
    prev0 = irq_n[0];
  end

  function automatic logic [8:0] a_cnt(int t);  return 9'(t * 64);      endfunction
  function automatic logic [8:0] a_base(int t); return 9'(t * 64 + 16); endfunction
  function automatic logic [8:0] a_ra(int t);   return 9'(t * 64 + 32); endfunction
  function automatic logic [8:0] a_rb(int t);   return 9'(t * 64 + 48); endfunction
  localparam logic [8:0] A_CTRL = 9'h100;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic wait_fall(int t, output int c, output bit ok);
    ok = 0; c = 0;
    for (int k = 0; k < 30000; k++) begin
      @(negedge clk);
      if (!irq_n[t]) begin c = cyc; ok = 1; break; end
    end
  endtask

  task automatic period(int t, output int p, output logic tg1, output logic tg2);
    int c1, c2; bit ok1, ok2; logic [31:0] d;
    wait_fall(t, c1, ok1); rd(a_cnt(t), d); tg1 = d[31];
    wait_fall(t, c2, ok2); rd(a_cnt(t), d); tg2 = d[31];
    p = (ok1 && ok2) ? c2 - c1 : -1;
  endtask

  task automatic halt(int t);
    logic [31:0] d;
    wr(a_base(t), 32'h8000_0000);
    wr(a_cnt(t), 32'd0);
    rd(a_cnt(t), d);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    int p; logic g1, g2;
    int nlist [4] = '{0, 1, 3, 6};
    int idx = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    chk("R1 irq_n", {28'd0, irq_n}, 32'hF);
    for (int t = 0; t < 4; t++) begin
      rd(a_base(t), d); chk("R1 base", d, 32'h8000_0000);
      rd(a_cnt(t), d);  chk("R1 count", d, 32'd0);
    end
    rd(A_CTRL, d); chk("R1 ctrl", d, 32'd0);

    for (int t = 0; t < 4; t++) begin
      wr(a_ra(t), 32'hA500_0000 | 32'(t * 32'h111));
      wr(a_rb(t), ~(32'hA500_0000 | 32'(t * 32'h111)));
      rd(a_ra(t), d); chk("R2 word A", d, 32'hA500_0000 | 32'(t * 32'h111));
      rd(a_rb(t), d); chk("R2 word B", d, ~(32'hA500_0000 | 32'(t * 32'h111)));
    end
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, d); chk("R2 ctrl mask", d, 32'h0700_0307);
    wr(A_CTRL, 32'd0);

    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 4; k++) begin
        int t = idx % 4;
        int n = nlist[k];
        idx++;
        wr(A_CTRL, 32'(s) << 8);
        rd(a_cnt(t), d);
        wr(a_base(t), 32'(n));
        period(t, p, g1, g2);
        chk("R3 period", 32'(p), 32'((n + 1) * (8 << s)));
        chk("R4 toggle flips", {31'd0, g1 ^ g2}, 32'd1);
        halt(t);
      end
    end

    wr(A_CTRL, 32'd0);
    wr(a_base(2), 32'd20);
    wait_fall(2, p, g1);
    repeat (10) @(negedge clk);
    chk("R11 level held", {31'd0, irq_n[2]}, 32'd0);
    rd(a_cnt(2), d);
    chk("R11 released by read", {31'd0, irq_n[2]}, 32'd1);
    halt(2);

    wr(a_base(3), 32'd30);
    repeat (50) @(negedge clk);
    wr(a_base(3), 32'h8000_001E);
    rd(a_cnt(3), d);
    chk("R5 counted before stop", {31'd0, d[30:0] < 31'd30}, 32'd1);
    repeat (300) @(negedge clk);
    rd(a_cnt(3), d2);
    chk("R5 stopped count held", d2, d);
    chk("R5 no irq while stopped", {31'd0, irq_n[3]}, 32'd1);
    wr(a_cnt(3), 32'h1234_5678); rd(a_cnt(3), d);
    chk("R5 count write zeroes", d, 32'd0);
    halt(3);

    wr(a_base(1), 32'h0000_1234);
    rd(a_cnt(1), d);
    chk("R6 start loads", {31'd0, (d == 32'h1234) || (d == 32'h1233)}, 32'd1);
    wr(a_base(1), 32'h0000_0500);
    rd(a_cnt(1), d);
    chk("R6 running write no reload", {31'd0, (d <= 32'h1234) && (d >= 32'h1230)}, 32'd1);
    halt(1);

    wr(A_CTRL, 32'h0100_0001);
    low_falls = 0;
    wr(a_base(0), 32'd2);
    wr(a_base(1), 32'd3);
    period(1, p, g1, g2);
    chk("R7 pair period", 32'(p), 32'(4 * 3 * 8));
    chk("R8 lower irq silent", 32'(low_falls), 32'd0);
    halt(1); halt(0);
    wr(a_base(0), 32'h8000_0002);
    wr(a_base(1), 32'd3);
    rd(a_cnt(0), d);
    chk("R7 lower full reload", {31'd0, (d == 32'h8000_0002) || (d == 32'h8000_0001)}, 32'd1);
    halt(1); halt(0);

    wr(A_CTRL, 32'h0000_0001);
    wr(a_base(0), 32'd1);
    period(0, p, g1, g2);
    chk("R9 no confirm stays stand-alone", 32'(p), 32'd16);
    halt(0);

    wr(A_CTRL, 32'h0300_0003);
    low_falls = 0;
    wr(a_base(2), 32'd2);
    period(2, p, g1, g2);
    chk("R10 losing pair timer stand-alone", 32'(p), 32'd24);
    wr(a_base(0), 32'd1);
    wr(a_base(1), 32'd1);
    period(1, p, g1, g2);
    chk("R10 winning pair period", 32'(p), 32'(2 * 2 * 8));
    chk("R8 lower silent in winning pair", 32'(low_falls), 32'd0);
    halt(1); halt(0); halt(2);

    done = 1;
    summary();
    $finish;
  end
endmodule